// File: doc/BRIEF.md
# Misaligned Byte-Addressed Data Scratchpad

This block is a 4 KB data scratchpad for a 32-bit scalar core. It serves byte, halfword and word loads and stores at any byte address, with no alignment restriction. A word or halfword may start at any byte offset. Its bytes are laid out big-endian, so the lowest address holds the most significant byte. An access that runs past the top of the array continues at address zero. The core never needs split or partial-word access sequences.

The core presents the full 32-bit effective address it computed. Only the low 12 bits pick the starting byte. A load returns its data on the cycle after the request, extended with either sign or zeros as the request asks. A store writes only the bytes it covers.

Storage is four byte-wide banks interleaved on the two low address bits. Any four consecutive bytes, wrapped or not, fall in four different banks, so every access takes a single cycle.

Top module: `scratch_dmem`

## Requirements
- R1: The array holds 4096 bytes. Only `req_addr[11:0]` selects the starting byte, so addresses that differ only in bits 31..12 reach the same bytes.
- R2: Multi-byte data is big-endian. After a word store of W at address A, the byte at A holds W[31:24] and the byte at A+3 holds W[7:0]. A word load at A returns the same W.
- R3: A word or halfword access is legal at any byte offset. A word load at A returns the four consecutive bytes A, A+1, A+2 and A+3, in that order from most to least significant.
- R4: Byte addressing is modulo 4096. An access that starts near 0xFFF continues at 0x000, for both loads and stores.
- R5: `req_size` = 01 selects a halfword. The load result is the two bytes in bits 15..0. With `req_signed` = 1, bits 31..16 copy bit 15. With `req_signed` = 0, bits 31..16 are zero.
- R6: `req_size` = 00 selects a byte. The load result is in bits 7..0. With `req_signed` = 1, bits 31..8 copy bit 7. With `req_signed` = 0, bits 31..8 are zero.
- R7: A store writes exactly 1, 2 or 4 bytes, and every other byte keeps its value. A byte store takes `req_wdata[7:0]`. A halfword store takes `req_wdata[15:0]`.
- R8: A load accepted on a clock edge (`req_valid` = 1, `req_write` = 0) raises `rsp_valid`, with its data, for exactly the following cycle. A store or an idle cycle leaves `rsp_valid` low on the next cycle.
- R9: While reset is asserted, and on every cycle where `rsp_valid` is low, `rsp_rdata` reads zero.
- R10: `req_size` = 10 selects a word. `req_size` = 11 is also treated as a word access, for both loads and stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Load extension: 1 = sign, 0 = zero |
| req_addr | input | 32 | Effective byte address (bits 11..0 used) |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Extended load data, zero when not valid |

## Verification
The bench aims at the cases where a word spans two 32-bit rows and where an access wraps from 0xFFF to 0x000. A bank-steering error there would return bytes from the wrong row or in rotated order. Halfword and byte loads are read back both signed and unsigned on values with the top bit set, which exposes a swapped or missing extension. Partial stores are placed between known neighbouring bytes, so a store enable that spills into other lanes shows up as a corrupted neighbour. Addresses with high bits set are also used, so a design that decodes beyond bit 11 fails the aliasing check.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  // Number of bytes touched by an access of the given size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Extend a right-justified load value according to size and sign mode.
  function automatic logic [WORD_W-1:0] extend_load(input logic [WORD_W-1:0] raw,
                                                    input logic [1:0] sz,
                                                    input logic sgn);
    case (sz)
      SZ_BYTE: extend_load = {{(WORD_W-8){sgn & raw[7]}}, raw[7:0]};
      SZ_HALF: extend_load = {{(WORD_W-16){sgn & raw[15]}}, raw[15:0]};
      default: extend_load = raw;
    endcase
  endfunction

endpackage

// File: rtl/sdm_lane_map.sv
module sdm_lane_map #(
  parameter int ADDR_W = 12,
  parameter int LANES  = sdm_pkg::WORD_BYTES,
  localparam int SEL_W = $clog2(LANES),
  localparam int ROW_W = ADDR_W - SEL_W
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [1:0]                    size,
  input  logic [8*LANES-1:0]            wdata,
  output logic [LANES-1:0][ROW_W-1:0]   bank_row,
  output logic [LANES-1:0]              bank_active,
  output logic [LANES-1:0][7:0]         bank_wbyte
);

  logic [2:0]         nbytes;
  logic [8*LANES-1:0] wdata_left;

  assign nbytes     = sdm_pkg::size_bytes(size);
  // Move the first stored byte to the top so byte k sits at a fixed slot.
  assign wdata_left = wdata << (8 * (LANES - int'(nbytes)));

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [SEL_W-1:0]  k;       // index of the access byte that lands here
    logic [ADDR_W-1:0] baddr;   // wrapped byte address for this bank
    assign k              = SEL_W'(b) - addr[SEL_W-1:0];
    assign baddr          = addr + ADDR_W'(k);
    assign bank_row[b]    = baddr[ADDR_W-1:SEL_W];
    assign bank_active[b] = ({1'b0, k} < nbytes);
    assign bank_wbyte[b]  = wdata_left[8*(LANES-1-int'(k)) +: 8];
  end

endmodule

// File: rtl/sdm_byte_bank.sv
module sdm_byte_bank #(
  parameter int ROW_W = 10,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wbyte;
      else    rbyte    <= mem[row];
    end
  end

endmodule

// File: rtl/sdm_load_align.sv
module sdm_load_align #(
  parameter int LANES  = sdm_pkg::WORD_BYTES,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][7:0] bank_rbyte,
  input  logic [SEL_W-1:0]      offset,
  input  logic [1:0]            size,
  input  logic                  sgn,
  output logic [8*LANES-1:0]    data
);

  logic [8*LANES-1:0] gathered;
  logic [8*LANES-1:0] justified;
  logic [2:0]         nbytes;

  assign nbytes = sdm_pkg::size_bytes(size);

  always_comb begin
    gathered = '0;
    for (int k = 0; k < LANES; k++) begin
      logic [SEL_W-1:0] src;
      src = offset + SEL_W'(k);
      gathered[8*(LANES-1-k) +: 8] = bank_rbyte[src];
    end
  end

  assign justified = gathered >> (8 * (LANES - int'(nbytes)));
  assign data      = sdm_pkg::extend_load(justified, size, sgn);

endmodule

// File: rtl/scratch_dmem.sv
module scratch_dmem #(
  parameter int ADDR_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);

  localparam int LANES = sdm_pkg::WORD_BYTES;
  localparam int SEL_W = $clog2(LANES);
  localparam int ROW_W = ADDR_W - SEL_W;

  // Named internal events for the checker.
  logic                       load_fire;
  logic                       store_fire;
  logic [LANES-1:0]           bank_en;
  logic [LANES-1:0]           bank_we;
  logic [LANES-1:0]           bank_active;
  logic [LANES-1:0][ROW_W-1:0] bank_row;
  logic [LANES-1:0][7:0]      bank_wbyte;
  logic [LANES-1:0][7:0]      bank_rbyte;
  logic [ADDR_W-1:0]          eff_addr;

  logic                       rsp_valid_q;
  logic [SEL_W-1:0]           rsp_off_q;
  logic [1:0]                 rsp_size_q;
  logic                       rsp_sgn_q;
  logic [31:0]                load_word;

  assign eff_addr   = req_addr[ADDR_W-1:0];
  assign load_fire  = req_valid & ~req_write;
  assign store_fire = req_valid &  req_write;

  sdm_lane_map #(.ADDR_W(ADDR_W), .LANES(LANES)) u_map (
    .addr        (eff_addr),
    .size        (req_size),
    .wdata       (req_wdata),
    .bank_row    (bank_row),
    .bank_active (bank_active),
    .bank_wbyte  (bank_wbyte)
  );

  assign bank_we = store_fire ? bank_active : '0;
  assign bank_en = load_fire ? '1 : bank_we;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    sdm_byte_bank #(.ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (bank_we[b]),
      .row   (bank_row[b]),
      .wbyte (bank_wbyte[b]),
      .rbyte (bank_rbyte[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_off_q   <= '0;
      rsp_size_q  <= 2'b00;
      rsp_sgn_q   <= 1'b0;
    end else begin
      rsp_valid_q <= load_fire;
      if (load_fire) begin
        rsp_off_q  <= eff_addr[SEL_W-1:0];
        rsp_size_q <= req_size;
        rsp_sgn_q  <= req_signed;
      end
    end
  end

  sdm_load_align #(.LANES(LANES)) u_align (
    .bank_rbyte (bank_rbyte),
    .offset     (rsp_off_q),
    .size       (rsp_size_q),
    .sgn        (rsp_sgn_q),
    .data       (load_word)
  );

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_valid_q ? load_word : 32'h0;

endmodule

// File: rtl/sdm_checker.sv
module sdm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic        req_signed,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [3:0]  bank_we
);

  assert_rsp_follows_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == 32'h0));

  assert_byte_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'b00 && !req_signed) |=> (rsp_rdata[31:8] == 24'h0));

  assert_byte_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'b00 && req_signed) |=> (rsp_rdata[31:8] == {24{rsp_rdata[7]}}));

  assert_half_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'b01 && !req_signed) |=> (rsp_rdata[31:16] == 16'h0));

  assert_half_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'b01 && req_signed) |=> (rsp_rdata[31:16] == {16{rsp_rdata[15]}}));

  assert_store_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |->
      ($countones(bank_we) == ((req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 : 4)));

  assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |-> (bank_we == 4'b0000));

endmodule

bind scratch_dmem sdm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_signed (req_signed),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .bank_we    (bank_we)
);

// File: tb/scratch_dmem_test.sv
module scratch_dmem_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic [31:0] req_wdata = 32'h0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [4096];

  always #10 clk = ~clk;

  scratch_dmem uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ref_load(input logic [31:0] a, input logic [1:0] sz, input logic sg);
    logic [31:0] v;
    int n;
    n = nb(sz);
    v = 0;
    for (int k = 0; k < n; k++) v = (v << 8) | 32'(model[(a + k) & 32'hFFF]);
    if (sg && n == 1 && v[7])  v = v | 32'hFFFF_FF00;
    if (sg && n == 2 && v[15]) v = v | 32'hFFFF_0000;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store(input string req, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    int n;
    n = nb(sz);
    for (int k = 0; k < n; k++) model[(a + k) & 32'hFFF] = 8'(d >> (8 * (n - 1 - k)));
    req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d; req_signed = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check({req, " store leaves rsp_valid low (R8)"}, {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic load_check(input string req, input logic [31:0] a, input logic [1:0] sz, input logic sg);
    logic [31:0] exp;
    exp = ref_load(a, sz, sg);
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz; req_signed = sg;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check({req, " rsp_valid (R8)"}, {31'b0, rsp_valid}, 32'd1);
    check(req, rsp_rdata, exp);
  endtask

  task automatic t_reset;
    check("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R9 reset rsp_rdata", rsp_rdata, 32'd0);
  endtask

  task automatic t_big_endian;
    store("R2", 32'h100, 2'b10, 32'h1122_3344);
    load_check("R2 word", 32'h100, 2'b10, 0);
    load_check("R2 first byte is MSB", 32'h100, 2'b00, 0);
    load_check("R2 last byte is LSB", 32'h103, 2'b00, 0);
  endtask

  task automatic t_misaligned;
    store("R3", 32'h000, 2'b10, 32'h0102_0304);
    store("R3", 32'h004, 2'b10, 32'h0506_0708);
    load_check("R3 word at 0x001", 32'h001, 2'b10, 0);
    load_check("R3 word at 0x003", 32'h003, 2'b10, 0);
    store("R3 misaligned word store", 32'h005, 2'b10, 32'hA1B2_C3D4);
    load_check("R3 readback 0x004", 32'h004, 2'b10, 0);
    load_check("R3 half at 0x003", 32'h003, 2'b01, 0);
  endtask

  task automatic t_wrap;
    store("R4 word wrap", 32'hFFE, 2'b10, 32'hCAFE_BABE);
    load_check("R4 byte at 0x000", 32'h000, 2'b00, 0);
    load_check("R4 word at 0xFFE", 32'hFFE, 2'b10, 0);
    load_check("R4 word at 0xFFD", 32'hFFD, 2'b10, 0);
    load_check("R4 half at 0xFFF", 32'hFFF, 2'b01, 0);
  endtask

  task automatic t_alias;
    store("R1 high bits", 32'hABCD_E010, 2'b10, 32'h5566_7788);
    load_check("R1 alias low", 32'h0000_0010, 2'b10, 0);
    load_check("R1 alias other high", 32'h7000_1012, 2'b01, 0);
  endtask

  task automatic t_half_ext;
    store("R5", 32'h041, 2'b01, 32'h0000_8001);
    load_check("R5 half signed neg", 32'h041, 2'b01, 1);
    load_check("R5 half unsigned", 32'h041, 2'b01, 0);
    store("R5", 32'h051, 2'b01, 32'hFFFF_7F00);
    load_check("R5 half signed pos", 32'h051, 2'b01, 1);
  endtask

  task automatic t_byte_ext;
    store("R6", 32'h060, 2'b00, 32'h0000_0080);
    load_check("R6 byte signed", 32'h060, 2'b00, 1);
    load_check("R6 byte unsigned", 32'h060, 2'b00, 0);
    store("R6", 32'h061, 2'b00, 32'hFFFF_FF7F);
    load_check("R6 byte signed pos", 32'h061, 2'b00, 1);
  endtask

  task automatic t_partial;
    store("R7 fill", 32'h200, 2'b10, 32'h1020_3040);
    store("R7 fill", 32'h204, 2'b10, 32'h5060_7080);
    store("R7 half over row edge", 32'h203, 2'b01, 32'hDEAD_BEEF);
    load_check("R7 lower row", 32'h200, 2'b10, 0);
    load_check("R7 upper row", 32'h204, 2'b10, 0);
    store("R7 byte low data", 32'h206, 2'b00, 32'hAABB_CC5A);
    load_check("R7 neighbours of byte", 32'h204, 2'b10, 0);
  endtask

  task automatic t_timing;
    load_check("R8 load", 32'h200, 2'b10, 0);
    @(posedge clk); @(negedge clk);
    check("R8 idle after load", {31'b0, rsp_valid}, 32'd0);
    check("R9 data zero when idle", rsp_rdata, 32'd0);
  endtask

  task automatic t_size3;
    store("R10 size 11 store", 32'h302, 2'b11, 32'h0BAD_F00D);
    load_check("R10 size 10 load", 32'h302, 2'b10, 0);
    load_check("R10 size 11 load", 32'h302, 2'b11, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_big_endian();
    t_misaligned();
    t_wrap();
    t_alias();
    t_half_ext();
    t_byte_ext();
    t_partial();
    t_timing();
    t_size3();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule